// File: doc/BRIEF.md
# Stalling Serial Transmitter with Line Control

This block is the sending half of a memory-mapped serial port. Software writes a byte to the data offset, and the block sends it on the output pin as an asynchronous frame. The frame is a low start bit, eight data bits beginning with the least significant, and a high stop bit. A control word at offset 4 sets the bit period and the way the output pin is driven. Software can write bytes back to back without polling. When the shifter is still busy, the block holds the bus write in a wait state. It takes the byte in the same cycle the current stop bit ends, so the next start bit follows with no idle gap.

The control word selects one of four pin sources: the shifter, the incoming line echoed straight back (remote loopback), a constant low (break) or a constant high. A separate bit sends the shifter output, instead of the input pin, to the neighbouring receiver. This lets a local self-test run without touching the wire. The bit period is taken from the divisor when a frame starts, so a rate change never bends a frame already on the line.

Top module: `serial_tx_port`

## Requirements
- R1: After reset, the control word reads 0, `tx_ready` is 1, `txd_pin` is 1 and `bus_ready` is 1.
- R2: Each frame on the line is a 0 start bit, the eight data bits with bit 0 first, then a 1 stop bit. The idle line is 1.
- R3: Every bit of a frame lasts exactly divisor + 1 clock cycles. The divisor is control bits 19:0, and a divisor of 0 gives one-cycle bits.
- R4: `tx_ready` is 0 from the cycle after a byte is taken until the stop bit ends, and 1 otherwise.
- R5: A data write (offset 0, `bus_we` = 1) to an idle shifter completes at once. A data write during a frame holds `bus_ready` at 0 until the last cycle of the stop bit. The byte is taken at that edge, and its start bit follows at once. No byte is lost.
- R6: With control bits 31:30 = 01, `txd_pin` equals `rxd_pin` in every cycle, and written bytes never reach the pin.
- R7: With control bits 31:30 = 10, `txd_pin` is 0. With 11, it is 1. Both hold while idle and while a frame is shifting.
- R8: With control bit 29 = 0, `rx_feed` equals `rxd_pin`. With bit 29 = 1, `rx_feed` carries the shifter's frame and ignores `rxd_pin`.
- R9: The control offset reads back bits 31:29 and 19:0 as written. Its other bits read 0, and a read of the data offset returns 0.
- R10: A divisor written during a frame leaves that frame's bit period unchanged and applies from the next frame.
- R11: Reads, and writes to any offset other than the data offset, complete with `bus_ready` = 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset: 0 data, 4 control |
| bus_wdata | input | 32 | Write data (data byte in bits 7:0) |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | 0 = access waits this cycle |
| tx_ready | output | 1 | Shifter can take a byte |
| rxd_pin | input | 1 | Serial input pin |
| txd_pin | output | 1 | Serial output pin |
| rx_feed | output | 1 | Serial stream handed to the receiver |

## Verification
The checker tests the pin-source rules on every cycle. It checks the echo, break and mark modes, the receiver feed when local loopback is off, and the start bit that goes out when `tx_ready` falls. It also checks that idle data writes and all control accesses never wait, and that an accepted data write always leaves the shifter busy. The bench scenarios are the only place that can show exact bit timing across divisors, data order within a frame, and the length of a stall and its gapless handover. They also show that a divisor changed in mid-frame does not alter the frame, and that the receiver feed carries the frame in local loopback.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    typedef enum logic [1:0] {
        LINE_SHIFT = 2'b00,
        LINE_ECHO  = 2'b01,
        LINE_SPACE = 2'b10,
        LINE_MARK  = 2'b11
    } line_mode_e;

    localparam int MODE_LSB  = 30;
    localparam int LLOOP_BIT = 29;
endpackage

// File: rtl/serial_bit_timer.sv
module serial_bit_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = run && (tmr_q.cnt == period);
        if (start) begin
            tmr_d.cnt = '0;
        end else if (run) begin
            tmr_d.cnt = tick ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DIV_W-1:0]  load_div,
    output logic              busy,
    output logic              finishing,
    output logic              ser_out
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] shreg;
        logic [DIV_W-1:0]   per;
    } shf_t;

    shf_t shf_d, shf_q;
    logic tick;

    serial_bit_timer #(.CNT_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (load),
        .run    (shf_q.busy),
        .period (shf_q.per),
        .tick   (tick)
    );

    always_comb begin
        shf_d     = shf_q;
        finishing = shf_q.busy && tick && (shf_q.idx == LAST_IDX);
        if (load) begin
            shf_d.busy  = 1'b1;
            shf_d.idx   = '0;
            shf_d.shreg = {1'b1, load_data, 1'b0};
            shf_d.per   = load_div;
        end else if (finishing) begin
            shf_d.busy  = 1'b0;
            shf_d.shreg = '1;
        end else if (shf_q.busy && tick) begin
            shf_d.idx   = shf_q.idx + 1'b1;
            shf_d.shreg = {1'b1, shf_q.shreg[FRAME_W-1:1]};
        end
    end

    assign busy    = shf_q.busy;
    assign ser_out = shf_q.busy ? shf_q.shreg[0] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q       <= '0;
            shf_q.shreg <= '1;
        end else begin
            shf_q <= shf_d;
        end
    end
endmodule

// File: rtl/serial_line_mux.sv
module serial_line_mux
    import serial_tx_pkg::*;
(
    input  line_mode_e mode,
    input  logic       lloop,
    input  logic       ser_out,
    input  logic       rxd_pin,
    output logic       txd_pin,
    output logic       rx_feed
);
    always_comb begin
        unique case (mode)
            LINE_SHIFT: txd_pin = ser_out;
            LINE_ECHO:  txd_pin = rxd_pin;
            LINE_SPACE: txd_pin = 1'b0;
            default:    txd_pin = 1'b1;
        endcase
        rx_feed = lloop ? ser_out : rxd_pin;
    end
endmodule

// File: rtl/serial_tx_port.sv
module serial_tx_port
    import serial_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 20,
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 0,
    parameter int CTRL_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              tx_ready,
    input  logic              rxd_pin,
    output logic              txd_pin,
    output logic              rx_feed
);
    typedef struct packed {
        line_mode_e       mode;
        logic             lloop;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  data_sel, ctrl_sel, load, busy, finishing, ser_out;
    logic  unused_bits;

    assign unused_bits = ^bus_wdata[LLOOP_BIT-1:DIV_W];

    serial_tx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (bus_wdata[DATA_W-1:0]),
        .load_div  (ctrl_q.div),
        .busy      (busy),
        .finishing (finishing),
        .ser_out   (ser_out)
    );

    serial_line_mux u_mux (
        .mode    (ctrl_q.mode),
        .lloop   (ctrl_q.lloop),
        .ser_out (ser_out),
        .rxd_pin (rxd_pin),
        .txd_pin (txd_pin),
        .rx_feed (rx_feed)
    );

    always_comb begin
        ctrl_d    = ctrl_q;
        data_sel  = bus_req && (bus_addr == ADDR_W'(DATA_OFS));
        ctrl_sel  = bus_req && (bus_addr == ADDR_W'(CTRL_OFS));
        load      = data_sel && bus_we && (!busy || finishing);
        bus_ready = !(data_sel && bus_we) || !busy || finishing;
        tx_ready  = !busy;
        if (ctrl_sel && bus_we) begin
            ctrl_d.mode  = line_mode_e'(bus_wdata[MODE_LSB+1:MODE_LSB]);
            ctrl_d.lloop = bus_wdata[LLOOP_BIT];
            ctrl_d.div   = bus_wdata[DIV_W-1:0];
        end
        bus_rdata = '0;
        if (ctrl_sel) begin
            bus_rdata[MODE_LSB+1:MODE_LSB] = ctrl_q.mode;
            bus_rdata[LLOOP_BIT]           = ctrl_q.lloop;
            bus_rdata[DIV_W-1:0]           = ctrl_q.div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker #(
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              tx_ready,
    input logic              rxd_pin,
    input logic              txd_pin,
    input logic              rx_feed,
    input logic [1:0]        line_mode,
    input logic              lloop
);
    logic data_wr;
    assign data_wr = bus_req && bus_we && (bus_addr == ADDR_W'(DATA_OFS));

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b00 && $fell(tx_ready)) |-> !txd_pin); // R2
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b00 && tx_ready) |-> txd_pin); // R4
    AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_ready) |-> bus_ready); // R5
    AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && bus_ready) |=> !tx_ready); // R5
    AST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b01) |-> (txd_pin == rxd_pin)); // R6
    AST_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b10) |-> !txd_pin); // R7
    AST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b11) |-> txd_pin); // R7
    AST_RX_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !lloop |-> (rx_feed == rxd_pin)); // R8
    AST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !data_wr) |-> bus_ready); // R11
endmodule

bind serial_tx_port serial_tx_checker #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .tx_ready  (tx_ready),
    .rxd_pin   (rxd_pin),
    .txd_pin   (txd_pin),
    .rx_feed   (rx_feed),
    .line_mode (ctrl_q.mode),
    .lloop     (ctrl_q.lloop)
);

// File: tb/sim_serial_tx_port.sv
`timescale 1ns/1ps
module sim_serial_tx_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, tx_ready, rxd_pin = 1'b1, txd_pin, rx_feed;

    int total = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_tx_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .tx_ready(tx_ready), .rxd_pin(rxd_pin),
        .txd_pin(txd_pin), .rx_feed(rx_feed)
    );

    // byte in 15:8, divisor in 7:0
    localparam logic [15:0] VEC [4] = '{16'hA5_00, 16'h3C_01, 16'h01_03, 16'hFE_06};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        waits = 0;
        while (!bus_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output logic rdy);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; rdy = bus_ready;
        @(posedge clk);
        #1;
        bus_req = 1'b0;
    endtask

    task automatic ctrl_write(input logic [31:0] d);
        int w;
        bus_write(3'd4, d, w);
        check("R11 control write wait cycles", w, 0);
    endtask

    // called right after the accepting edge; checks every cycle of the frame
    task automatic check_frame(input logic [7:0] data, input int div, input bit use_feed,
                               input bit expect_idle);
        int bad_bits = 0, bad_rdy = 0;
        for (int b = 0; b < 10; b++) begin
            logic e;
            e = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : data[b-1];
            for (int c = 0; c <= div; c++) begin
                @(negedge clk);
                if ((use_feed ? rx_feed : txd_pin) !== e) bad_bits++;
                if (tx_ready !== 1'b0) bad_rdy++;
            end
        end
        check("R2 R3 frame bit mismatches", bad_bits, 0);
        check("R4 tx_ready low during frame", bad_rdy, 0);
        if (expect_idle) begin
            @(negedge clk);
            check("R4 tx_ready after stop", tx_ready, 1);
            check("R2 idle line after stop", use_feed ? rx_feed : txd_pin, 1);
        end
    endtask

    task automatic watch_const(input string tag, input logic exp, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd_pin !== exp) bad++;
        end
        check(tag, bad, 0);
    endtask

    task automatic wait_idle();
        while (!tx_ready) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic rdy;
        int w;

        repeat (3) @(negedge clk);
        check("R1 txd after reset", txd_pin, 1);
        check("R1 tx_ready after reset", tx_ready, 1);
        check("R1 bus_ready after reset", bus_ready, 1);
        rst_n = 1'b1;
        bus_read(3'd4, rd, rdy);
        check("R1 control after reset", rd, 0);

        // table walk: R2 R3 R4 R5 over several bytes and divisors
        for (int i = 0; i < 4; i++) begin
            ctrl_write({24'h0, VEC[i][7:0]});
            bus_write(3'd0, {24'h0, VEC[i][15:8]}, w);
            check("R5 idle data write waits", w, 0);
            check_frame(VEC[i][15:8], int'(VEC[i][7:0]), 1'b0, 1'b1);
        end

        // R9 readback
        ctrl_write(32'hFFFF_FFFF);
        bus_read(3'd4, rd, rdy);
        check("R9 control readback", rd, 32'hE00F_FFFF);
        check("R11 read ready", rdy, 1);
        bus_read(3'd0, rd, rdy);
        check("R9 data offset read", rd, 0);

        // R5 stall with gapless handover
        ctrl_write(32'd2);
        bus_write(3'd0, 32'h96, w);
        fork
            check_frame(8'h96, 2, 1'b0, 1'b0);
            bus_write(3'd0, 32'h5A, w);
        join
        check("R5 stall cycles", w, 10 * 3 - 1);
        check_frame(8'h5A, 2, 1'b0, 1'b1);

        // R10 divisor change mid-frame
        ctrl_write(32'd3);
        bus_write(3'd0, 32'hC6, w);
        fork
            check_frame(8'hC6, 3, 1'b0, 1'b1);
            begin
                repeat (5) @(negedge clk);
                ctrl_write(32'd1);
            end
        join
        bus_write(3'd0, 32'h39, w);
        check_frame(8'h39, 1, 1'b0, 1'b1);

        // R6 remote loopback
        ctrl_write(32'h4000_0001);
        bus_write(3'd0, 32'h00, w);
        begin
            int bad = 0, badf = 0;
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                rxd_pin = i[1] ^ i[0];
                #1;
                if (txd_pin !== rxd_pin) bad++;
                if (rx_feed !== rxd_pin) badf++;
            end
            check("R6 txd follows rxd", bad, 0);
            check("R8 feed follows rxd pin", badf, 0);
        end
        rxd_pin = 1'b1;
        wait_idle();

        // R7 break and mark
        ctrl_write(32'h8000_0000);
        watch_const("R7 break while idle", 1'b0, 4);
        bus_write(3'd0, 32'hFF, w);
        watch_const("R7 break while shifting", 1'b0, 8);
        wait_idle();
        ctrl_write(32'hC000_0000);
        bus_write(3'd0, 32'h00, w);
        watch_const("R7 mark while shifting", 1'b1, 8);
        wait_idle();

        // R8 local loopback: feed carries frame, rxd ignored
        ctrl_write(32'h2000_0001);
        rxd_pin = 1'b0;
        bus_write(3'd0, 32'hC3, w);
        check_frame(8'hC3, 1, 1'b1, 1'b1);
        rxd_pin = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule